// File: doc/BRIEF.md
# Timed Pulse-Train Generator

This block drives a single output pin with a periodic pulse train whose first edge is set to an absolute point in time. A free-running system time arrives on two buses, whole seconds and nanoseconds within the second. A separate strobe marks each sub-second increment tick. Software programs a target second, a target nanosecond, a period and a high time through a small register port. It then issues a start command. The generator waits until the system time reaches the target, then starts the train. The period and the high time are counted in increment ticks and are written as "count minus one".

A busy flag is shown in the target-nanoseconds register. It rises when a new target nanosecond value is written. It drops when the target is reached or when the pending start is cancelled. While it is high, further target writes are refused. A stop command lets the current period finish before the output returns low. A start is only taken when the global enable bit is set and the target-mode field selects pulse-output-only operation.

Top module: `pps_pulse_gen`

## Requirements
- R1: After reset, `pulse_out` is 0 and all five registers read back as 0. The registers are: control at address 0, target seconds at 1, target nanoseconds at 2, period at 3 and high time at 4.
- R2: A write to target nanoseconds while the busy flag is clear stores the value and sets the busy flag. The flag reads back at bit 31 of address 2, and the nanoseconds sit in the low bits.
- R3: While the busy flag is set, writes to target seconds and target nanoseconds are ignored, and their readback is unchanged.
- R4: A control write with command field bits [3:0] = 2, mode field bits [5:4] = 2 and enable bit 8 = 1 arms the generator. `pulse_out` stays 0 while the system time is below the target.
- R5: An armed generator fires when the system time is greater than or equal to the target. This covers an exact match, and also a later second with a smaller nanosecond value. The busy flag clears in the same cycle.
- R6: From the firing edge, `pulse_out` is high for (high time + 1) ticks and then low for the rest of a period of (period + 1) ticks. This repeats every period.
- R7: A control write with command 5 during a running train keeps the pattern until the end of the current period. After that, `pulse_out` is 0 and stays 0.
- R8: Command 5 written while armed but before the target is reached cancels the start. The busy flag clears, and no pulse appears when the time later passes the target.
- R9: A start command with the enable bit at 0, or with a mode field other than 2, is ignored. No pulse appears, and the busy flag stays set.
- R10: The period and the high time are captured when the train starts. Writes to them during a running train do not change that train.
- R11: When the high time is greater than or equal to the period, `pulse_out` stays high for the whole time the train runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_sec | input | SEC_W | System time, seconds |
| sys_ns | input | NS_W | System time, nanoseconds |
| tick | input | 1 | One-cycle sub-second increment strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Register read data, combinational |
| pulse_out | output | 1 | Pulse-train output |

## Verification
The bench builds the block with SEC_W=8, NS_W=10 and CNT_W=6. These narrow widths let it place targets at the top of the nanosecond range (1023). They also let it cross a seconds boundary with a smaller nanosecond value in a handful of cycles. Periods of 2 to 6 ticks keep several full periods, and a stop landing mid-period, inside short windows. Each stop is checked against the computed period boundary, and each high time against the tick count since firing.

// File: rtl/pps_gen_pkg.sv
package pps_gen_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_TSEC = 3'd1,
    REG_TNS  = 3'd2,
    REG_IVAL = 3'd3,
    REG_WID  = 3'd4
  } reg_addr_e;

  localparam logic [3:0] CMD_START  = 4'h2;
  localparam logic [3:0] CMD_STOP   = 4'h5;
  localparam logic [1:0] MODE_PULSE = 2'd2;

  localparam int CTRL_CMD_LSB  = 0;
  localparam int CTRL_MODE_LSB = 4;
  localparam int CTRL_EN_BIT   = 8;
endpackage

// File: rtl/pps_regs.sv
module pps_regs
  import pps_gen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              match,
  output logic [SEC_W-1:0]  tsec_o,
  output logic [NS_W-1:0]   tns_o,
  output logic [CNT_W-1:0]  ival_o,
  output logic [CNT_W-1:0]  wid_o,
  output logic              start_cmd,
  output logic              stop_cmd
);
  localparam int BUSY_BIT = DATA_W - 1;

  logic [SEC_W-1:0] tsec_q, tsec_d;
  logic [NS_W-1:0]  tns_q, tns_d;
  logic [CNT_W-1:0] ival_q, ival_d;
  logic [CNT_W-1:0] wid_q, wid_d;
  logic [1:0]       mode_q, mode_d;
  logic             en_q, en_d;
  logic             busy_q, busy_d;

  logic       ctrl_wr, tsec_wr, tns_wr, ival_wr, wid_wr;
  logic [3:0] cmd_w;
  logic [1:0] mode_w;
  logic       en_w;

  assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);
  assign tsec_wr = wr_en && (wr_addr == REG_TSEC) && !busy_q;
  assign tns_wr  = wr_en && (wr_addr == REG_TNS)  && !busy_q;
  assign ival_wr = wr_en && (wr_addr == REG_IVAL);
  assign wid_wr  = wr_en && (wr_addr == REG_WID);

  assign cmd_w  = wr_data[CTRL_CMD_LSB +: 4];
  assign mode_w = wr_data[CTRL_MODE_LSB +: 2];
  assign en_w   = wr_data[CTRL_EN_BIT];

  assign start_cmd = ctrl_wr && (cmd_w == CMD_START) && en_w && (mode_w == MODE_PULSE);
  assign stop_cmd  = ctrl_wr && (cmd_w == CMD_STOP);

  always_comb begin
    tsec_d = tsec_q;
    tns_d  = tns_q;
    ival_d = ival_q;
    wid_d  = wid_q;
    mode_d = mode_q;
    en_d   = en_q;
    busy_d = busy_q;
    if (ctrl_wr) begin
      mode_d = mode_w;
      en_d   = en_w;
    end
    if (tsec_wr) tsec_d = wr_data[SEC_W-1:0];
    if (tns_wr)  tns_d  = wr_data[NS_W-1:0];
    if (ival_wr) ival_d = wr_data[CNT_W-1:0];
    if (wid_wr)  wid_d  = wr_data[CNT_W-1:0];
    if (tns_wr)                  busy_d = 1'b1;
    else if (stop_cmd || match)  busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsec_q <= '0;
      tns_q  <= '0;
      ival_q <= '0;
      wid_q  <= '0;
      mode_q <= '0;
      en_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (tsec_wr) tsec_q <= tsec_d;
      if (tns_wr)  tns_q  <= tns_d;
      if (ival_wr) ival_q <= ival_d;
      if (wid_wr)  wid_q  <= wid_d;
      if (ctrl_wr) begin
        mode_q <= mode_d;
        en_q   <= en_d;
      end
      busy_q <= busy_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_CTRL: begin
        rd_data[CTRL_MODE_LSB +: 2] = mode_q;
        rd_data[CTRL_EN_BIT]        = en_q;
      end
      REG_TSEC: rd_data[SEC_W-1:0] = tsec_q;
      REG_TNS: begin
        rd_data[NS_W-1:0] = tns_q;
        rd_data[BUSY_BIT] = busy_q;
      end
      REG_IVAL: rd_data[CNT_W-1:0] = ival_q;
      REG_WID:  rd_data[CNT_W-1:0] = wid_q;
      default:  rd_data = '0;
    endcase
  end

  assign tsec_o = tsec_q;
  assign tns_o  = tns_q;
  assign ival_o = ival_q;
  assign wid_o  = wid_q;

  assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_TNS && !busy_q) |=> busy_q);
  assert_tgt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == REG_TNS || wr_addr == REG_TSEC) && busy_q)
      |=> ($stable(tns_q) && $stable(tsec_q)));
endmodule

// File: rtl/pps_trigger.sv
module pps_trigger #(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] sys_sec,
  input  logic [NS_W-1:0]  sys_ns,
  input  logic [SEC_W-1:0] tsec,
  input  logic [NS_W-1:0]  tns,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  output logic             match
);
  logic armed_q, armed_d;
  logic reached;

  assign reached = (sys_sec > tsec) || ((sys_sec == tsec) && (sys_ns >= tns));
  assign match   = armed_q && reached;

  always_comb begin
    armed_d = armed_q;
    if (start_cmd)                armed_d = 1'b1;
    else if (stop_cmd || match)   armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assert_stop_cancels_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cmd && !start_cmd) |=> !match);
endmodule

// File: rtl/pps_train.sv
module pps_train #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop_cmd,
  input  logic             tick,
  input  logic [CNT_W-1:0] ival_in,
  input  logic [CNT_W-1:0] wid_in,
  output logic             pulse
);
  logic             run_q, run_d;
  logic             stop_q, stop_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] ival_q, ival_d;
  logic [CNT_W-1:0] wid_q, wid_d;
  logic             at_end;

  assign at_end = (cnt_q == ival_q);

  always_comb begin
    run_d  = run_q;
    stop_d = stop_q;
    cnt_d  = cnt_q;
    ival_d = ival_q;
    wid_d  = wid_q;
    if (start) begin
      run_d  = 1'b1;
      stop_d = 1'b0;
      cnt_d  = '0;
      ival_d = ival_in;
      wid_d  = wid_in;
    end else if (run_q) begin
      if (stop_cmd) stop_d = 1'b1;
      if (tick) begin
        if (at_end) begin
          cnt_d = '0;
          if (stop_q || stop_cmd) begin
            run_d  = 1'b0;
            stop_d = 1'b0;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      stop_q <= 1'b0;
      cnt_q  <= '0;
      ival_q <= '0;
      wid_q  <= '0;
    end else begin
      run_q  <= run_d;
      stop_q <= stop_d;
      cnt_q  <= cnt_d;
      if (start) begin
        ival_q <= ival_d;
        wid_q  <= wid_d;
      end
    end
  end

  assign pulse = run_q && (cnt_q <= wid_q);

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= ival_q));
  assert_stop_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(tick && at_end));
endmodule

// File: rtl/pps_pulse_gen.sv
module pps_pulse_gen
  import pps_gen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEC_W-1:0]  sys_sec,
  input  logic [NS_W-1:0]   sys_ns,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              pulse_out
);
  logic rst_meta_q, rst_sync_n;
  logic [SEC_W-1:0] tsec;
  logic [NS_W-1:0]  tns;
  logic [CNT_W-1:0] ival, wid;
  logic start_cmd, stop_cmd, match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  pps_regs #(.DATA_W(DATA_W), .SEC_W(SEC_W), .NS_W(NS_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .match(match),
    .tsec_o(tsec), .tns_o(tns), .ival_o(ival), .wid_o(wid),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd)
  );

  pps_trigger #(.SEC_W(SEC_W), .NS_W(NS_W)) u_trigger (
    .clk(clk), .rst_n(rst_sync_n),
    .sys_sec(sys_sec), .sys_ns(sys_ns),
    .tsec(tsec), .tns(tns),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .match(match)
  );

  pps_train #(.CNT_W(CNT_W)) u_train (
    .clk(clk), .rst_n(rst_sync_n),
    .start(match), .stop_cmd(stop_cmd), .tick(tick),
    .ival_in(ival), .wid_in(wid),
    .pulse(pulse_out)
  );

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> !pulse_out);
endmodule

// File: tb/test_pps_pulse_gen.sv
module test_pps_pulse_gen;
  localparam int DATA_W = 32, SEC_W = 8, NS_W = 10, CNT_W = 6;
  localparam logic [31:0] C_CFG = 32'h120, C_START = 32'h122, C_STOP = 32'h125;
  localparam logic [31:0] BUSY = 32'h8000_0000;

  typedef struct packed {
    logic [5:0] ival;
    logic [5:0] wid;
    logic [7:0] tsec;
    logic [9:0] tns;
    logic       late;
  } vec_t;
  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{6'd3, 6'd1, 8'd5,  10'd100,  1'b0},
    '{6'd4, 6'd0, 8'd7,  10'd1,    1'b0},
    '{6'd2, 6'd2, 8'd9,  10'd500,  1'b0},
    '{6'd5, 6'd2, 8'd12, 10'd600,  1'b1},
    '{6'd1, 6'd0, 8'd20, 10'd1023, 1'b1}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, wr_en, tick, pulse_out;
  logic [2:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [SEC_W-1:0] sys_sec;
  logic [NS_W-1:0] sys_ns;
  int errors = 0, checks = 0;
  logic [31:0] r;

  pps_pulse_gen #(.DATA_W(DATA_W), .SEC_W(SEC_W), .NS_W(NS_W), .CNT_W(CNT_W)) i_pps_pulse_gen (
    .clk(clk), .rst_n(rst_n), .sys_sec(sys_sec), .sys_ns(sys_ns), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pulse_out(pulse_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic step(input logic t);
    tick = t; @(negedge clk); tick = 1'b0;
  endtask

  function automatic logic expect_hi(input int k, input int p, input int w);
    return (k % p) <= w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; tick = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; sys_sec = '0; sys_ns = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 pulse", {31'd0, pulse_out}, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r); chk("R1 reg", r, 0);
    end

    // Main vector table: R2..R7, R11
    for (int v = 0; v < NV; v++) begin
      int p, w, k, b;
      p = int'(VEC[v].ival) + 1;
      w = int'(VEC[v].wid);
      sys_sec = 0; sys_ns = 0;
      wr(3'd0, C_CFG);
      wr(3'd1, 32'(VEC[v].tsec));
      wr(3'd2, 32'(VEC[v].tns));
      rd(3'd2, r); chk("R2 busy+tns", r, BUSY | 32'(VEC[v].tns));
      wr(3'd1, 32'(VEC[v].tsec) + 3);
      wr(3'd2, 32'(VEC[v].tns ^ 10'd1));
      rd(3'd1, r); chk("R3 tsec held", r, 32'(VEC[v].tsec));
      rd(3'd2, r); chk("R3 tns held", r, BUSY | 32'(VEC[v].tns));
      wr(3'd3, 32'(VEC[v].ival));
      wr(3'd4, 32'(VEC[v].wid));
      if (VEC[v].late) begin sys_sec = VEC[v].tsec - 1; sys_ns = 10'd1023; end
      else begin sys_sec = VEC[v].tsec; sys_ns = VEC[v].tns - 1; end
      wr(3'd0, C_START);
      for (int i = 0; i < 3; i++) begin
        step(1'b1); chk("R4 low before target", {31'd0, pulse_out}, 0);
      end
      if (VEC[v].late) begin sys_sec = VEC[v].tsec + 1; sys_ns = 10'd0; end
      else begin sys_sec = VEC[v].tsec; sys_ns = VEC[v].tns; end
      step(1'b0);
      k = 0;
      chk("R5 fires on reach", {31'd0, pulse_out}, 1);
      rd(3'd2, r); chk("R5 busy cleared", r, 32'(VEC[v].tns));
      for (int i = 0; i < 2 * p; i++) begin
        step(1'b1); k++;
        chk((w >= p - 1) ? "R11 always high" : "R6 pattern",
            {31'd0, pulse_out}, {31'd0, expect_hi(k, p, w)});
      end
      wr(3'd0, C_STOP);
      b = (k / p + 1) * p;
      for (int i = 0; i < p + 1; i++) begin
        step(1'b1); k++;
        chk("R7 finish period", {31'd0, pulse_out},
            (k < b) ? {31'd0, expect_hi(k, p, w)} : 32'd0);
      end
    end

    // R9 start ignored without enable or with wrong mode
    sys_sec = 0; sys_ns = 0;
    wr(3'd1, 32'd30);
    wr(3'd2, 32'd5);
    wr(3'd0, 32'h022);
    sys_sec = 40;
    for (int i = 0; i < 3; i++) begin
      step(1'b1); chk("R9 no enable", {31'd0, pulse_out}, 0);
    end
    rd(3'd2, r); chk("R9 busy stays", r, BUSY | 32'd5);
    sys_sec = 0;
    wr(3'd0, 32'h112);
    sys_sec = 40;
    for (int i = 0; i < 3; i++) begin
      step(1'b1); chk("R9 wrong mode", {31'd0, pulse_out}, 0);
    end
    wr(3'd0, C_STOP);
    rd(3'd2, r); chk("R8 stop clears busy", r, 32'd5);

    // R8 cancel before target
    sys_sec = 0;
    wr(3'd2, 32'd7);
    wr(3'd0, C_START);
    step(1'b1);
    wr(3'd0, C_STOP);
    rd(3'd2, r); chk("R8 busy cleared", r, 32'd7);
    sys_sec = 50;
    for (int i = 0; i < 4; i++) begin
      step(1'b1); chk("R8 no pulse", {31'd0, pulse_out}, 0);
    end

    // R10 period/high time captured at start
    begin
      int k;
      sys_sec = 0;
      wr(3'd1, 32'd60);
      wr(3'd2, 32'd0);
      wr(3'd3, 32'd3);
      wr(3'd4, 32'd1);
      wr(3'd0, C_START);
      sys_sec = 60;
      step(1'b0);
      k = 0;
      chk("R10 start", {31'd0, pulse_out}, 1);
      step(1'b1); step(1'b1); k = 2;
      wr(3'd3, 32'd7);
      wr(3'd4, 32'd6);
      for (int i = 0; i < 6; i++) begin
        step(1'b1); k++;
        chk("R10 old values", {31'd0, pulse_out}, {31'd0, expect_hi(k, 4, 1)});
      end
      wr(3'd0, C_STOP);
      repeat (5) step(1'b1);
      chk("R7 stopped", {31'd0, pulse_out}, 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule